// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. Two component predictors look at the branch address. The first uses the outcomes of the most recent branches, held in one shift register. The second uses the recent outcomes of that same branch, held in a per-address history table. A table of per-address saturating counters learns which of the two has been right more often for each branch. That table picks the final answer.

The fetch side presents an address and reads four combinational results: the final direction, both component guesses and the chooser's pick. Once the branch resolves, the pipeline sends back the address, the real outcome and the two component guesses it saw at fetch. On each resolve cycle the block trains both counter tables, shifts the outcome into both histories and trains the chooser. One prediction and one resolve are accepted per cycle. Histories are never repaired speculatively. A build-time option replaces the plain global-history index with the history XORed with low address bits.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every counter is weakly not-taken, so every address reads all outputs as 0. This covers predTaken, predGlobal, predLocal and predUseGlobal (0 = local). Global and per-branch histories are cleared.
- R2: On each cycle with updValid high, the global history shifts left by one with updTaken entering bit 0. With updValid low it holds.
- R3: The global table holds 2-bit saturating counters (0..3), reset to 1. predGlobal is the MSB of the counter selected by the current global history. A resolve increments or decrements that counter, selected by the history before the shift, toward updTaken.
- R4: The per-branch history table is indexed by the low LHIST_IDX_W address bits. A resolve shifts updTaken into bit 0 of that entry.
- R5: The local counter table holds 3-bit saturating counters (0..7), reset to 3, indexed by the branch's per-branch history. predLocal is 1 when the counter is 4 or more. A resolve moves the counter, selected by the history before the shift, toward updTaken.
- R6: The chooser holds 2-bit counters indexed by the low SEL_IDX_W address bits, reset to 1. predUseGlobal is its MSB, and predTaken is predGlobal when predUseGlobal is 1 and predLocal otherwise.
- R7: A chooser counter increments (saturating at 3) when only updGlobalPred equalled updTaken. It decrements (saturating at 0) when only updLocalPred did. It holds when both or neither were right.
- R8: When a prediction and a resolve address the same entries in one cycle, the prediction shows the values from before that resolve.
- R9: While updValid is low, the update inputs change no table or history, whatever their values.
- R10: With GSHARE set, the global table is indexed, for both reading and training, by the global history XORed with the low GHIST_W address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| predPc | input | PC_W | Branch address being fetched |
| predTaken | output | 1 | Final direction guess |
| predGlobal | output | 1 | Global-history component guess |
| predLocal | output | 1 | Per-branch-history component guess |
| predUseGlobal | output | 1 | Chooser pick, 1 = global |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome |
| updGlobalPred | input | 1 | Global guess made for it at fetch |
| updLocalPred | input | 1 | Local guess made for it at fetch |

## Verification
The checker watches several properties on every cycle. It checks the global-history shift and hold (R2). It checks that the chooser reads weakly local straight after reset (R1). It checks that the chooser for a watched address keeps its direction, or moves only the allowed way, after each kind of resolve (R7). Counter saturation, the two-level indexing, gshare aliasing and read-before-write need the bench's reference model. The bench drives long mixed outcome patterns and sweeps every small-table entry. Junk update cycles with updValid low and same-cycle prediction and resolve are likewise shown only by those scenarios.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef struct packed {
    logic histShift;   // shift outcome into both histories
    logic cntWrite;    // train both direction counter tables
    logic selUp;       // chooser toward global
    logic selDown;     // chooser toward local
    logic outcome;     // resolved direction
  } tpStrobes_t;

  localparam int GCNT_W = 2;
  localparam int LCNT_W = 3;
  localparam int SCNT_W = 2;
  localparam int GCNT_INIT = 1;
  localparam int LCNT_INIT = 3;
  localparam int SCNT_INIT = 1;

endpackage

// File: rtl/tp_cnt_table.sv
module tp_cnt_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 2,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdMsb,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrUp
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(INIT);

  logic [CNT_W-1:0] cntQ [DEPTH];
  logic [CNT_W-1:0] curCnt;
  logic [CNT_W-1:0] nextCnt;

  assign rdMsb  = cntQ[rdIdx][CNT_W-1];
  assign curCnt = cntQ[wrIdx];

  always_comb begin
    nextCnt = curCnt;
    if (wrUp && curCnt != CNT_MAX) nextCnt = curCnt + 1'b1;
    else if (!wrUp && curCnt != '0) nextCnt = curCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cntQ[i] <= CNT_RST;
    end else if (wrEn) begin
      cntQ[wrIdx] <= nextCnt;
    end
  end
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updGlobalPred,
  input  logic       updLocalPred,
  output tpStrobes_t strb
);
  logic globalRight;
  logic localRight;

  assign globalRight = (updGlobalPred == updTaken);
  assign localRight  = (updLocalPred == updTaken);

  always_comb begin
    strb.histShift = updValid;
    strb.cntWrite  = updValid;
    strb.outcome   = updTaken;
    strb.selUp     = updValid && globalRight && !localRight;
    strb.selDown   = updValid && !globalRight && localRight;
  end
endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int GHIST_W     = 6,
  parameter int LHIST_IDX_W = 4,
  parameter int LHIST_W     = 5,
  parameter int SEL_IDX_W   = 5,
  parameter bit GSHARE      = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  tpStrobes_t         strb,
  input  logic [PC_W-1:0]    predPc,
  input  logic [PC_W-1:0]    updPc,
  output logic               predGlobal,
  output logic               predLocal,
  output logic               predUseGlobal,
  output logic [GHIST_W-1:0] globalHist
);
  localparam int LH_DEPTH = 1 << LHIST_IDX_W;

  logic [GHIST_W-1:0]     gHistQ;
  logic [LHIST_W-1:0]     lHistQ [LH_DEPTH];
  logic [GHIST_W-1:0]     gRdIdx;
  logic [GHIST_W-1:0]     gWrIdx;
  logic [LHIST_IDX_W-1:0] lhRdSlot;
  logic [LHIST_IDX_W-1:0] lhWrSlot;
  logic [LHIST_W-1:0]     lRdHist;
  logic [LHIST_W-1:0]     lWrHist;

  assign globalHist = gHistQ;

  generate
    if (GSHARE) begin : gIdxHashed
      assign gRdIdx = gHistQ ^ predPc[GHIST_W-1:0];
      assign gWrIdx = gHistQ ^ updPc[GHIST_W-1:0];
    end else begin : gIdxPlain
      assign gRdIdx = gHistQ;
      assign gWrIdx = gHistQ;
    end
  endgenerate

  assign lhRdSlot = predPc[LHIST_IDX_W-1:0];
  assign lhWrSlot = updPc[LHIST_IDX_W-1:0];
  assign lRdHist  = lHistQ[lhRdSlot];
  assign lWrHist  = lHistQ[lhWrSlot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gHistQ <= '0;
    end else if (strb.histShift) begin
      gHistQ <= {gHistQ[GHIST_W-2:0], strb.outcome};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LH_DEPTH; i++) lHistQ[i] <= '0;
    end else if (strb.histShift) begin
      lHistQ[lhWrSlot] <= {lWrHist[LHIST_W-2:0], strb.outcome};
    end
  end

  tp_cnt_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W), .INIT(GCNT_INIT)) globalTab (
    .clk(clk), .rstN(rstN),
    .rdIdx(gRdIdx), .rdMsb(predGlobal),
    .wrEn(strb.cntWrite), .wrIdx(gWrIdx), .wrUp(strb.outcome)
  );

  tp_cnt_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W), .INIT(LCNT_INIT)) localTab (
    .clk(clk), .rstN(rstN),
    .rdIdx(lRdHist), .rdMsb(predLocal),
    .wrEn(strb.cntWrite), .wrIdx(lWrHist), .wrUp(strb.outcome)
  );

  tp_cnt_table #(.IDX_W(SEL_IDX_W), .CNT_W(SCNT_W), .INIT(SCNT_INIT)) chooserTab (
    .clk(clk), .rstN(rstN),
    .rdIdx(predPc[SEL_IDX_W-1:0]), .rdMsb(predUseGlobal),
    .wrEn(strb.selUp || strb.selDown), .wrIdx(updPc[SEL_IDX_W-1:0]),
    .wrUp(strb.selUp)
  );
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int GHIST_W     = 6,
  parameter int LHIST_IDX_W = 4,
  parameter int LHIST_W     = 5,
  parameter int SEL_IDX_W   = 5,
  parameter bit GSHARE      = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic            predGlobal,
  output logic            predLocal,
  output logic            predUseGlobal,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updGlobalPred,
  input  logic            updLocalPred
);
  tpStrobes_t         strb;
  logic [GHIST_W-1:0] globalHist;

  tp_ctrl ctrl (
    .updValid(updValid), .updTaken(updTaken),
    .updGlobalPred(updGlobalPred), .updLocalPred(updLocalPred),
    .strb(strb)
  );

  tp_datapath #(
    .PC_W(PC_W), .GHIST_W(GHIST_W), .LHIST_IDX_W(LHIST_IDX_W),
    .LHIST_W(LHIST_W), .SEL_IDX_W(SEL_IDX_W), .GSHARE(GSHARE)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .predPc(predPc), .updPc(updPc),
    .predGlobal(predGlobal), .predLocal(predLocal),
    .predUseGlobal(predUseGlobal), .globalHist(globalHist)
  );

  assign predTaken = predUseGlobal ? predGlobal : predLocal;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PC_W    = 12,
  parameter int GHIST_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [PC_W-1:0]    predPc,
  input logic               predUseGlobal,
  input logic               updValid,
  input logic [PC_W-1:0]    updPc,
  input logic               updTaken,
  input logic               updGlobalPred,
  input logic               updLocalPred,
  input logic [GHIST_W-1:0] globalHist
);
  logic gOk;
  logic lOk;
  logic samePc;
  assign gOk    = (updGlobalPred == updTaken);
  assign lOk    = (updLocalPred == updTaken);
  assign samePc = (predPc == updPc);

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> globalHist == {$past(globalHist[GHIST_W-2:0]), $past(updTaken)}); // R2

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(globalHist)); // R9

  AST_RESET_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predUseGlobal); // R1

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && samePc && (gOk == lOk)) |=>
      (predPc != $past(predPc)) || (predUseGlobal == $past(predUseGlobal))); // R7

  AST_SEL_STAY_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && samePc && gOk && !lOk && predUseGlobal) |=>
      (predPc != $past(predPc)) || predUseGlobal); // R7

  AST_SEL_STAY_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && samePc && !gOk && lOk && !predUseGlobal) |=>
      (predPc != $past(predPc)) || !predUseGlobal); // R7
endmodule

bind tourney_predictor tp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) chk (
  .clk(clk), .rstN(rstN), .predPc(predPc), .predUseGlobal(predUseGlobal),
  .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
  .updGlobalPred(updGlobalPred), .updLocalPred(updLocalPred),
  .globalHist(globalHist)
);

// File: tb/tourney_predictor_test.sv
module tourney_predictor_test;
  localparam int PERIOD = 10;
  localparam int PCW = 12;
  localparam int GH  = 6;
  localparam int LI  = 4;
  localparam int LH  = 5;
  localparam int SI  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PCW-1:0] predPc = '0;
  logic [PCW-1:0] updPc = '0;
  logic updValid = 1'b0, updTaken = 1'b0, updGlobalPred = 1'b0, updLocalPred = 1'b0;
  logic predTaken, predGlobal, predLocal, predUseGlobal;
  logic xTaken, xGlobal, xLocal, xUse;

  always #(PERIOD/2) clk = ~clk;

  tourney_predictor uut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .predGlobal(predGlobal), .predLocal(predLocal), .predUseGlobal(predUseGlobal),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updGlobalPred(updGlobalPred), .updLocalPred(updLocalPred)
  );

  tourney_predictor #(.GSHARE(1'b1)) uutX (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(xTaken),
    .predGlobal(xGlobal), .predLocal(xLocal), .predUseGlobal(xUse),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updGlobalPred(updGlobalPred), .updLocalPred(updLocalPred)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int gT0 [1<<GH];
  int gT1 [1<<GH];
  int lh  [1<<LI];
  int lT  [1<<LH];
  int sl  [1<<SI];
  int gh;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (pc %0d)", req, act, exp, predPc);
    end
  endtask

  function automatic int mGlob(int pc, bit gs);
    int idx = gs ? ((gh ^ pc) & ((1<<GH)-1)) : gh;
    return gs ? (gT1[idx] >= 2) : (gT0[idx] >= 2);
  endfunction
  function automatic int mLoc(int pc);
    return lT[lh[pc & ((1<<LI)-1)]] >= 4;
  endfunction
  function automatic int mSel(int pc);
    return sl[pc & ((1<<SI)-1)] >= 2;
  endfunction
  function automatic int sat(int v, bit up, int mx);
    if (up) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < (1<<GH); i++) begin gT0[i] = 1; gT1[i] = 1; end
    for (int i = 0; i < (1<<LI); i++) lh[i] = 0;
    for (int i = 0; i < (1<<LH); i++) lT[i] = 3;
    for (int i = 0; i < (1<<SI); i++) sl[i] = 1;
    gh = 0;
  endtask

  task automatic modelUpdate(int pc, bit t, bit gp, bit lp);
    int i0 = gh;
    int i1 = (gh ^ pc) & ((1<<GH)-1);
    int ls = pc & ((1<<LI)-1);
    int si = pc & ((1<<SI)-1);
    gT0[i0] = sat(gT0[i0], t, 3);
    gT1[i1] = sat(gT1[i1], t, 3);
    lT[lh[ls]] = sat(lT[lh[ls]], t, 7);
    if (gp == t && lp != t) sl[si] = sat(sl[si], 1'b1, 3);
    if (gp != t && lp == t) sl[si] = sat(sl[si], 1'b0, 3);
    lh[ls] = ((lh[ls] << 1) | t) & ((1<<LH)-1);
    gh = ((gh << 1) | t) & ((1<<GH)-1);
  endtask

  task automatic checkAll(int pc, string tagSfx);
    int g = mGlob(pc, 0), l = mLoc(pc), s = mSel(pc);
    chk({"R3", tagSfx}, predGlobal, g);
    chk({"R5", tagSfx}, predLocal, l);
    chk({"R6", tagSfx}, predUseGlobal, s);
    chk({"R6", tagSfx}, predTaken, s ? g : l);
    chk({"R10", tagSfx}, xGlobal, mGlob(pc, 1));
    chk({"R4", tagSfx}, xLocal, l);
  endtask

  function automatic bit outcomeOf(int pc, int it);
    case (pc % 4)
      0: return (it % 5) != 4;
      1: return it[0];
      2: return gh[0];
      default: return lfsr[7];
    endcase
  endfunction

  task automatic advance();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: every address reads not-taken, chooser local
    for (int pc = 0; pc < 64; pc++) begin
      @(negedge clk); predPc = PCW'(pc); #1;
      chk("R1", {predTaken, predGlobal, predLocal, predUseGlobal}, 0);
    end
    for (int it = 0; it < 3000; it++) begin
      int pc;
      bit t, gp, lp;
      advance();
      pc = (it % 3 == 0) ? int'(lfsr[11:0]) : int'(lfsr[4:0]);
      t = outcomeOf(pc, it);
      @(negedge clk);
      updValid = 1'b0;
      predPc = PCW'(pc); #1;
      checkAll(pc, "");
      gp = lfsr[5] ? predGlobal : lfsr[8];
      lp = lfsr[5] ? predLocal  : lfsr[9];
      updValid = 1'b1; updPc = PCW'(pc); updTaken = t;
      updGlobalPred = gp; updLocalPred = lp; #1;
      // R8: same-cycle resolve must not disturb this prediction
      checkAll(pc, "_R8");
      @(posedge clk);
      modelUpdate(pc, t, gp, lp);
      if (it % 300 == 299) begin
        // R9: junk update fields with updValid low, then sweep
        @(negedge clk);
        updValid = 1'b0; updPc = lfsr[11:0]; updTaken = 1'b1;
        updGlobalPred = 1'b0; updLocalPred = 1'b1;
        for (int p = 0; p < 32; p++) begin
          @(negedge clk); predPc = PCW'(p); #1;
          checkAll(p, "_R9");
        end
      end
    end
    updValid = 1'b0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule